// File: doc/BRIEF.md
# Accumulator Register with Extended Bit and Function Select

This block holds a 16-bit accumulator and the one-bit extension flag that catches carries and the bit that rotates out. Each clock it applies at most one accumulator function, chosen from a set of decoded strobes: bitwise AND with the data operand, add with the data operand, copy of the data operand, load of an input byte, inversion, rotate right or left through the extension flag, clear, and increment. Two further strobes act on the extension flag alone. They clear it or invert it.

The sequencer that raises the strobes sits outside this block. It also supplies the data operand and the input byte. The block outputs the accumulator, the extension flag and four status levels. A skip decision can use these levels without any further logic: sign clear, sign set, accumulator zero and extension zero.

Top module: `acc_unit`

## Requirements
- R1: While `rst_n` is low, the accumulator and the extension flag are held at 0. Both stay 0 until the first strobe after reset is released.
- R2: Strobe bit 0 (AND) loads the accumulator with the accumulator ANDed with `dr_i` at the next rising edge.
- R3: Strobe bit 1 (ADD) loads the accumulator with the low 16 bits of accumulator plus `dr_i`. It loads the extension flag with the carry out of bit 15.
- R4: Strobe bit 2 (copy) loads the accumulator with `dr_i`.
- R5: Strobe bit 3 (input load) writes `in_byte_i` into accumulator bits 7..0 and clears bits 15..8.
- R6: Strobe bit 4 (invert) loads the accumulator with its bitwise complement.
- R7: Strobe bit 5 (rotate right) shifts the accumulator down one place. The old extension flag enters bit 15, and the old bit 0 moves into the extension flag.
- R8: Strobe bit 6 (rotate left) shifts the accumulator up one place. The old extension flag enters bit 0, and the old bit 15 moves into the extension flag.
- R9: Strobe bit 7 clears the accumulator. Strobe bit 8 adds 1 to it modulo 2^16. Neither changes the extension flag.
- R10: Strobe bit 9 clears the extension flag and strobe bit 10 inverts it; bit 9 wins if both are set. Both are ignored in a cycle where the selected accumulator function is ADD or a rotate.
- R11: If several of strobe bits 0..8 are set together, only the lowest-numbered one takes effect.
- R12: With no strobe set, the accumulator and the extension flag keep their values.
- R13: `ac_pos_o` is 1 exactly when accumulator bit 15 is 0, and `ac_neg_o` exactly when it is 1. `ac_zero_o` is 1 when the accumulator is 0, and `e_zero_o` when the extension flag is 0. All four follow the registered values with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_strb_i | input | 11 | Decoded function strobes, bit positions as in the requirements |
| dr_i | input | 16 | Data operand |
| in_byte_i | input | 8 | Input character byte |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Extension flag |
| ac_pos_o | output | 1 | Accumulator sign bit is 0 |
| ac_neg_o | output | 1 | Accumulator sign bit is 1 |
| ac_zero_o | output | 1 | Accumulator equals 0 |
| e_zero_o | output | 1 | Extension flag equals 0 |

## Verification
The accumulator and the extension flag are both visible at the ports. A wrong value in either therefore shows on `ac_o` or `e_o` one clock after the offending strobe, and on the status levels in the same cycle. The corruptions that are hardest to see are an extension flag left wrong by a rotate or an add, and a wrong priority pick between strobes. Either can leave the accumulator correct for one cycle and only show up at a later rotate, add or skip test. For that reason the stimulus chains rotates and adds back to back, and it compares every output on every clock.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int unsigned OP_AND   = 0;
  localparam int unsigned OP_ADD   = 1;
  localparam int unsigned OP_XFER  = 2;
  localparam int unsigned OP_INB   = 3;
  localparam int unsigned OP_CMA   = 4;
  localparam int unsigned OP_ROR   = 5;
  localparam int unsigned OP_ROL   = 6;
  localparam int unsigned OP_CLRA  = 7;
  localparam int unsigned OP_INC   = 8;
  localparam int unsigned OP_CLRE  = 9;
  localparam int unsigned OP_CMPE  = 10;
  localparam int unsigned N_AC_OPS = 9;
  localparam int unsigned N_OPS    = 11;
endpackage

// File: rtl/acc_func_sel.sv
module acc_func_sel #(
  parameter int unsigned N = 9
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] sel_o
);
  // Lowest index wins; a running mask records lower requests.
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_pick
    assign sel_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req_i[i];
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IN_W   = 8
) (
  input  logic [N_AC_OPS-1:0] sel_i,
  input  logic [DATA_W-1:0]   ac_i,
  input  logic                e_i,
  input  logic [DATA_W-1:0]   dr_i,
  input  logic [IN_W-1:0]     in_byte_i,
  output logic [DATA_W-1:0]   ac_nxt_o,
  output logic                ac_we_o,
  output logic                e_out_o,
  output logic                e_out_vld_o
);
  localparam int unsigned PAD_W = DATA_W - IN_W;

  function automatic logic [DATA_W:0] add_c(input logic [DATA_W-1:0] a,
                                            input logic [DATA_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [DATA_W:0] rot_r(input logic [DATA_W-1:0] a, input logic ein);
    // result: {new_e, new_ac}
    return {a[0], ein, a[DATA_W-1:1]};
  endfunction

  function automatic logic [DATA_W:0] rot_l(input logic [DATA_W-1:0] a, input logic ein);
    return {a[DATA_W-1], a[DATA_W-2:0], ein};
  endfunction

  logic [DATA_W:0] sum_w, ror_w, rol_w;
  assign sum_w = add_c(ac_i, dr_i);
  assign ror_w = rot_r(ac_i, e_i);
  assign rol_w = rot_l(ac_i, e_i);

  assign ac_we_o     = |sel_i;
  assign e_out_vld_o = sel_i[OP_ADD] | sel_i[OP_ROR] | sel_i[OP_ROL];

  always_comb begin
    ac_nxt_o = ac_i;
    e_out_o  = e_i;
    if (sel_i[OP_AND])  ac_nxt_o = ac_i & dr_i;
    if (sel_i[OP_ADD])  {e_out_o, ac_nxt_o} = sum_w;
    if (sel_i[OP_XFER]) ac_nxt_o = dr_i;
    if (sel_i[OP_INB])  ac_nxt_o = {{PAD_W{1'b0}}, in_byte_i};
    if (sel_i[OP_CMA])  ac_nxt_o = ~ac_i;
    if (sel_i[OP_ROR])  {e_out_o, ac_nxt_o} = ror_w;
    if (sel_i[OP_ROL])  {e_out_o, ac_nxt_o} = rol_w;
    if (sel_i[OP_CLRA]) ac_nxt_o = '0;
    if (sel_i[OP_INC])  ac_nxt_o = ac_i + DATA_W'(1);
  end
endmodule

// File: rtl/acc_e_ctl.sv
module acc_e_ctl (
  input  logic e_i,
  input  logic e_out_i,
  input  logic e_out_vld_i,
  input  logic clr_i,
  input  logic cmp_i,
  output logic e_nxt_o
);
  always_comb begin
    if (e_out_vld_i)  e_nxt_o = e_out_i;
    else if (clr_i)   e_nxt_o = 1'b0;
    else if (cmp_i)   e_nxt_o = ~e_i;
    else              e_nxt_o = e_i;
  end
endmodule

// File: rtl/acc_status.sv
module acc_status #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] ac_i,
  input  logic              e_i,
  output logic              pos_o,
  output logic              neg_o,
  output logic              zero_o,
  output logic              e_zero_o
);
  assign neg_o    = ac_i[DATA_W-1];
  assign pos_o    = ~ac_i[DATA_W-1];
  assign zero_o   = ~|ac_i;
  assign e_zero_o = ~e_i;
endmodule

// File: rtl/acc_unit.sv
module acc_unit
  import acc_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IN_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_OPS-1:0]  op_strb_i,
  input  logic [DATA_W-1:0] dr_i,
  input  logic [IN_W-1:0]   in_byte_i,
  output logic [DATA_W-1:0] ac_o,
  output logic              e_o,
  output logic              ac_pos_o,
  output logic              ac_neg_o,
  output logic              ac_zero_o,
  output logic              e_zero_o
);
  logic [DATA_W-1:0]   ac_q, ac_nxt;
  logic                e_q, e_nxt, e_out, e_out_vld, ac_we;
  logic [N_AC_OPS-1:0] ac_sel;

  acc_func_sel #(.N(N_AC_OPS)) u_sel (
    .req_i (op_strb_i[N_AC_OPS-1:0]),
    .sel_o (ac_sel)
  );

  acc_alu #(.DATA_W(DATA_W), .IN_W(IN_W)) u_alu (
    .sel_i       (ac_sel),
    .ac_i        (ac_q),
    .e_i         (e_q),
    .dr_i        (dr_i),
    .in_byte_i   (in_byte_i),
    .ac_nxt_o    (ac_nxt),
    .ac_we_o     (ac_we),
    .e_out_o     (e_out),
    .e_out_vld_o (e_out_vld)
  );

  acc_e_ctl u_ectl (
    .e_i         (e_q),
    .e_out_i     (e_out),
    .e_out_vld_i (e_out_vld),
    .clr_i       (op_strb_i[OP_CLRE]),
    .cmp_i       (op_strb_i[OP_CMPE]),
    .e_nxt_o     (e_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q <= '0;
      e_q  <= 1'b0;
    end else begin
      if (ac_we) ac_q <= ac_nxt;
      e_q <= e_nxt;
    end
  end

  acc_status #(.DATA_W(DATA_W)) u_stat (
    .ac_i     (ac_q),
    .e_i      (e_q),
    .pos_o    (ac_pos_o),
    .neg_o    (ac_neg_o),
    .zero_o   (ac_zero_o),
    .e_zero_o (e_zero_o)
  );

  assign ac_o = ac_q;
  assign e_o  = e_q;
endmodule

// File: rtl/acc_unit_chk.sv
module acc_unit_chk
  import acc_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_OPS-1:0]  op_strb_i,
  input logic [DATA_W-1:0] ac_o,
  input logic              e_o,
  input logic              ac_pos_o,
  input logic              ac_neg_o,
  input logic              ac_zero_o,
  input logic              e_zero_o,
  input logic [N_AC_OPS-1:0] ac_sel
);
  localparam logic [N_OPS-1:0] M_INC = N_OPS'(1) << OP_INC;
  localparam logic [N_OPS-1:0] M_INB = N_OPS'(1) << OP_INB;
  localparam logic [N_OPS-1:0] M_ROR = N_OPS'(1) << OP_ROR;
  localparam logic [N_OPS-1:0] M_ROL = N_OPS'(1) << OP_ROL;

  // R12
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_strb_i == '0) |=> ($stable(ac_o) && $stable(e_o)));

  // R9
  inc_keeps_e_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_strb_i == M_INC) |=> ($stable(e_o) && ac_o == $past(ac_o) + DATA_W'(1)));

  // R5
  inb_high_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_strb_i == M_INB) |=> (ac_o[DATA_W-1:8] == '0));

  // R7
  ror_e_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_strb_i == M_ROR) |=> (ac_o[DATA_W-1] == $past(e_o) && e_o == $past(ac_o[0])));

  // R8
  rol_e_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_strb_i == M_ROL) |=> (ac_o[0] == $past(e_o) && e_o == $past(ac_o[DATA_W-1])));

  // R11
  one_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ac_sel));

  // R13
  sign_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_pos_o != ac_neg_o));

  // R13
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ac_zero_o |-> (!ac_neg_o && e_zero_o == !e_o));
endmodule

bind acc_unit acc_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_strb_i (op_strb_i),
  .ac_o      (ac_o),
  .e_o       (e_o),
  .ac_pos_o  (ac_pos_o),
  .ac_neg_o  (ac_neg_o),
  .ac_zero_o (ac_zero_o),
  .e_zero_o  (e_zero_o),
  .ac_sel    (ac_sel)
);

// File: tb/acc_unit_tb_top.sv
module acc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] op = '0;
  logic [15:0] dr = '0;
  logic [7:0]  inb = '0;
  logic [15:0] ac;
  logic        e, pos, neg, zro, ez;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  bit          done = 0;

  logic [15:0] m_ac = '0;
  logic        m_e = 1'b0;
  string       pend_tag = "R1";

  always #4 clk = ~clk;

  acc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_strb_i(op), .dr_i(dr), .in_byte_i(inb),
    .ac_o(ac), .e_o(e), .ac_pos_o(pos), .ac_neg_o(neg),
    .ac_zero_o(zro), .e_zero_o(ez)
  );

  task automatic compare(input string tag);
    logic [3:0] fl_exp, fl_act;
    fl_exp = {~m_ac[15], m_ac[15], (m_ac == 16'h0), ~m_e};
    fl_act = {pos, neg, zro, ez};
    n_chk++;
    if (ac !== m_ac || e !== m_e || fl_act !== fl_exp) begin
      n_fail++;
      $display("FAIL %s/R13: ac=%h e=%b flags=%b expected ac=%h e=%b flags=%b",
               tag, ac, e, fl_act, m_ac, m_e, fl_exp);
    end
  endtask

  // Behavioural next-state of the accumulator pair.
  task automatic model(input logic [10:0] o, input logic [15:0] d, input logic [7:0] b);
    int first = -1;
    bit e_set = 0;
    logic [16:0] s;
    logic [15:0] a = m_ac;
    logic        x = m_e;
    for (int i = 0; i < 9; i++) if (o[i] && first < 0) first = i;
    case (first)
      0: a = m_ac & d;
      1: begin s = m_ac + d; a = s[15:0]; x = s[16]; e_set = 1; end
      2: a = d;
      3: a = 16'(b);
      4: a = ~m_ac;
      5: begin a = {m_e, m_ac[15:1]}; x = m_ac[0]; e_set = 1; end
      6: begin a = {m_ac[14:0], m_e}; x = m_ac[15]; e_set = 1; end
      7: a = 16'h0;
      8: a = m_ac + 16'h1;
      default: ;
    endcase
    if (!e_set) begin
      if (o[9]) x = 1'b0;
      else if (o[10]) x = ~m_e;
    end
    m_ac = a;
    m_e  = x;
  endtask

  task automatic step(input logic [10:0] o, input logic [15:0] d, input logic [7:0] b,
                      input string tag);
    @(negedge clk);
    compare(pend_tag);
    op = o; dr = d; inb = b;
    model(o, d, b);
    pend_tag = tag;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    // R4 copy, then R2 AND
    step(11'h004, 16'hA5F0, 8'h00, "R4");
    step(11'h001, 16'h0FF3, 8'h00, "R2");
    // R3 add without and with carry out
    step(11'h004, 16'hFFFF, 8'h00, "R4");
    step(11'h002, 16'h0001, 8'h00, "R3");
    step(11'h002, 16'h1234, 8'h00, "R3");
    step(11'h002, 16'h8000, 8'h00, "R3");
    step(11'h002, 16'h9000, 8'h00, "R3");
    // R12 hold
    step(11'h000, 16'hFFFF, 8'hFF, "R12");
    step(11'h000, 16'h0000, 8'h00, "R12");
    // R5 input byte over a full accumulator
    step(11'h004, 16'hFFFF, 8'h00, "R4");
    step(11'h008, 16'h0000, 8'h5A, "R5");
    // R6 invert
    step(11'h010, 16'h0000, 8'h00, "R6");
    // R7 / R8 rotate chains through E
    for (int k = 0; k < 18; k++) step(11'h020, 16'h0, 8'h0, "R7");
    for (int k = 0; k < 18; k++) step(11'h040, 16'h0, 8'h0, "R8");
    // R9 clear, increment with E kept, wrap to zero
    step(11'h200, 16'h0, 8'h0, "R10");
    step(11'h400, 16'h0, 8'h0, "R10");
    step(11'h004, 16'hFFFE, 8'h0, "R4");
    step(11'h100, 16'h0, 8'h0, "R9");
    step(11'h100, 16'h0, 8'h0, "R9");
    step(11'h080, 16'h0, 8'h0, "R9");
    // R10 E-only strobes, both together, and ignored next to add/rotate
    step(11'h600, 16'h0, 8'h0, "R10");
    step(11'h400, 16'h0, 8'h0, "R10");
    step(11'h400, 16'h0, 8'h0, "R10");
    step(11'h602, 16'h0001, 8'h0, "R10");
    step(11'h004, 16'h8001, 8'h0, "R4");
    step(11'h420, 16'h0, 8'h0, "R10");
    step(11'h240, 16'h0, 8'h0, "R10");
    step(11'h090, 16'h0, 8'h0, "R10");
    // R11 priority among simultaneous accumulator strobes
    step(11'h1FF, 16'h3C3C, 8'h77, "R11");
    step(11'h1FE, 16'hF00F, 8'h77, "R11");
    step(11'h1F8, 16'hF00F, 8'h77, "R11");
    step(11'h1E0, 16'h0, 8'h0, "R11");
    step(11'h180, 16'h0, 8'h0, "R11");
    step(11'h030, 16'h0, 8'h0, "R11");
    // Flags at sign and zero corners (R13)
    step(11'h004, 16'h7FFF, 8'h0, "R13");
    step(11'h100, 16'h0, 8'h0, "R13");
    step(11'h004, 16'h0000, 8'h0, "R13");
    step(11'h000, 16'h0, 8'h0, "R13");
    @(negedge clk);
    compare(pend_tag);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule